// File: doc/BRIEF.md
# Exception Vector Arbiter

This block sits beside a small 8-bit CPU core and decides which exception the core takes next. It takes several inputs: a reset pin and an internal reset request, a strobe that marks the fetch of a software-interrupt opcode, the core's interrupt mask bit, an external interrupt pin, and a group of peripheral interrupt requests. From these it picks one exception and presents the two 16-bit addresses from which the core reads the vector's high and low bytes.

The core takes the presented exception by pulsing an acknowledge. One cycle later the block asks the core to set its mask bit. A memory-mapped control byte holds two things: the enable for the external interrupt, and a two-bit code that selects which pin condition counts as a request. The block also contains the detector for that pin condition.

The software interrupt cannot be masked. Hardware requests that were already pending when its opcode was fetched are taken before it, and requests that arrive later are taken after it.

Top module: `exc_vector_arbiter`

## Requirements
- R1: A low `ext_reset_n`, a high `int_reset`, or a block reset (`rst_n` low) selects the reset exception, with vector addresses 0x3FFE (high byte) and 0x3FFF (low byte). It stays selected while the reset request is held and until the core acknowledges it after release.
- R2: Acknowledging any presented exception drives `set_imask` high for exactly the one cycle that follows the acknowledge cycle.
- R3: A pulse on `swi_fetch` makes the software interrupt (vectors 0x3FFC/0x3FFD) pending. It is taken even while `i_mask` is 1.
- R4: The external interrupt and peripheral requests that are active and unmasked in the `swi_fetch` cycle are taken before the software interrupt. Requests that become active afterwards are taken after it.
- R5: While `i_mask` is 1, neither the external interrupt nor a peripheral request is selected.
- R6: The external interrupt is recognized only when bit 0 (enable) of the control byte at bus address 0x0A is 1 and `i_mask` is 0.
- R7: Control bits [2:1] select the pin condition: 00 falling edge, 01 rising edge, 10 either edge. A detected edge stays pending until the external interrupt is acknowledged.
- R8: Code 11 selects a low level. It is not latched: the request is present only while `irq_pin` is low.
- R9: Among requests not ordered by a software interrupt, the external interrupt (vectors 0x3FFA/0x3FFB) wins over peripheral requests (vectors 0x3FF8/0x3FF9). The low-byte address is always the high-byte address plus one.
- R10: The control byte reads back on `bus_rdata` when `bus_addr` is 0x0A, with bits [7:3] reading 0. A block reset or a reset request clears it to 0.
- R11: `exc_kind` encodes 0 none, 1 reset, 2 external interrupt, 3 software interrupt, 4 peripheral. `exc_take` is 1 exactly when `exc_kind` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ext_reset_n | input | 1 | External reset pin, active low |
| int_reset | input | 1 | Internal reset request |
| swi_fetch | input | 1 | Strobe: software-interrupt opcode fetched |
| i_mask | input | 1 | Core interrupt mask bit |
| irq_pin | input | 1 | External interrupt pin |
| periph_req | input | NPER | Peripheral interrupt requests |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| exc_ack | input | 1 | Core takes the presented exception |
| exc_take | output | 1 | An exception is presented |
| exc_kind | output | 3 | Selected exception code |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_lo_addr | output | 16 | Address of the vector low byte |
| set_imask | output | 1 | Request to set the core mask bit |

## Verification
The bench targets the ordering around the software interrupt:
- It starts with a hardware request that is active before the strobe and adds a peripheral request after it. A design that only kept a fixed priority would take the late peripheral before the software interrupt, or would take the software interrupt before the earlier request.
- It switches between edge and level sensing. A detector that latched a low level would keep requesting after the pin rose. One that forgot an edge while masked would lose the interrupt when the mask cleared.
- It holds reset requests with a control byte that is not zero, to confirm that the byte clears.
- It confirms that the mask-set request comes exactly one cycle after each acknowledge.

// File: rtl/exc_pkg.sv
// Package: shared exception codes and vector offsets for the arbiter.
// Assumes the vector table is a block of four byte pairs above a base address.
package exc_pkg;
    typedef enum logic [2:0] {
        EXC_NONE   = 3'd0,
        EXC_RESET  = 3'd1,
        EXC_IRQ    = 3'd2,
        EXC_SWI    = 3'd3,
        EXC_PERIPH = 3'd4
    } exc_kind_e;

    localparam int HW_SRC  = 2;
    localparam int HW_IRQ  = 0;
    localparam int HW_PER  = 1;

    typedef enum logic [1:0] {
        SENSE_FALL  = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_BOTH  = 2'b10,
        SENSE_LEVEL = 2'b11
    } sense_e;

    // Offset of the high-byte location from the vector base for each kind
    function automatic logic [15:0] vec_offset(exc_kind_e k);
        case (k)
            EXC_RESET:  return 16'd6;
            EXC_SWI:    return 16'd4;
            EXC_IRQ:    return 16'd2;
            default:    return 16'd0;
        endcase
    endfunction
endpackage

// File: rtl/exc_sysctl.sv
// Module: system control byte holding the pin-interrupt enable and sense code.
// Assumes a single-cycle write strobe; reads are combinational.
module exc_sysctl #(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_en,
    output logic [1:0]        irq_mode
);
    localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(3'b111);

    logic [DATA_W-1:0] ctl_q;
    logic              hit;

    assign hit = (bus_addr == CTL_ADDR);

    // Purpose: hold the control byte, cleared by any reset source
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ctl_q <= '0;
        else if (bus_we && hit)
            ctl_q <= bus_wdata & CTL_MASK;
    end

    // Purpose: read mux for the control byte
    always_comb begin
        bus_rdata = hit ? ctl_q : '0;
    end

    assign irq_en   = ctl_q[0];
    assign irq_mode = ctl_q[2:1];

    AST_CTL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ctl_q == '0)); // R10
endmodule

// File: rtl/exc_irq_sense.sv
// Module: external interrupt pin condition detector.
// Edges are found against the pin registered one clock earlier (idle high).
// A detected edge is held until acknowledged; low-level mode is not held.
module exc_irq_sense
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       irq_pin,
    input  logic       irq_en,
    input  logic [1:0] irq_mode,
    input  logic       irq_ack,
    output logic       irq_active
);
    logic   pin_q;
    logic   edge_pend;
    logic   edge_hit;
    sense_e mode;

    assign mode = sense_e'(irq_mode);

    // Purpose: decide whether the selected edge occurred this cycle
    always_comb begin
        case (mode)
            SENSE_FALL: edge_hit = pin_q & ~irq_pin;
            SENSE_RISE: edge_hit = ~pin_q & irq_pin;
            SENSE_BOTH: edge_hit = pin_q ^ irq_pin;
            default:    edge_hit = 1'b0;
        endcase
    end

    // Purpose: register the pin and hold detected edges until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pin_q     <= 1'b1;
            edge_pend <= 1'b0;
        end else begin
            pin_q <= irq_pin;
            if (!irq_en || mode == SENSE_LEVEL)
                edge_pend <= 1'b0;
            else if (edge_hit)
                edge_pend <= 1'b1;
            else if (irq_ack)
                edge_pend <= 1'b0;
        end
    end

    // Purpose: present the request according to the sense mode
    always_comb begin
        if (!irq_en)
            irq_active = 1'b0;
        else if (mode == SENSE_LEVEL)
            irq_active = ~irq_pin;
        else
            irq_active = edge_pend;
    end

    AST_LEVEL_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LEVEL && irq_pin) |-> !irq_active); // R8
    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pend && irq_en && !irq_ack && !clr && mode != SENSE_LEVEL
         && $stable(irq_mode)) |=> edge_pend); // R7
endmodule

// File: rtl/exc_priority.sv
// Module: fixed-priority exception selector with ordering around the
// software interrupt. Assumes the core acknowledges only while a kind is shown.
module exc_priority
    import exc_pkg::*;
#(
    parameter int NPER = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reset_cond,
    input  logic            i_mask,
    input  logic            irq_active,
    input  logic [NPER-1:0] periph_req,
    input  logic            swi_fetch,
    input  logic            exc_ack,
    output exc_kind_e       kind,
    output logic            irq_ack,
    output logic            set_imask
);
    logic              rst_pend;
    logic              swi_pend;
    logic [HW_SRC-1:0] pre_swi;
    logic [HW_SRC-1:0] hw_req;
    logic [HW_SRC-1:0] pre_hw;
    logic [HW_SRC-1:0] hw_taken;
    logic              taken;

    // Purpose: mask-qualified hardware requests
    always_comb begin
        hw_req[HW_IRQ] = ~i_mask & irq_active;
        hw_req[HW_PER] = ~i_mask & (|periph_req);
        pre_hw         = hw_req & pre_swi;
    end

    // Purpose: pick one exception by fixed priority
    always_comb begin
        if (reset_cond || rst_pend)
            kind = EXC_RESET;
        else if (swi_pend && pre_hw[HW_IRQ])
            kind = EXC_IRQ;
        else if (swi_pend && pre_hw[HW_PER])
            kind = EXC_PERIPH;
        else if (swi_pend)
            kind = EXC_SWI;
        else if (hw_req[HW_IRQ])
            kind = EXC_IRQ;
        else if (hw_req[HW_PER])
            kind = EXC_PERIPH;
        else
            kind = EXC_NONE;
    end

    // Purpose: decode which source the acknowledge retires
    always_comb begin
        taken            = exc_ack && (kind != EXC_NONE);
        hw_taken[HW_IRQ] = exc_ack && (kind == EXC_IRQ);
        hw_taken[HW_PER] = exc_ack && (kind == EXC_PERIPH);
        irq_ack          = hw_taken[HW_IRQ];
    end

    // Purpose: pending flags, pre-SWI snapshot and mask-set request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend  <= 1'b1;
            swi_pend  <= 1'b0;
            pre_swi   <= '0;
            set_imask <= 1'b0;
        end else begin
            set_imask <= taken;
            if (reset_cond)
                rst_pend <= 1'b1;
            else if (exc_ack && kind == EXC_RESET)
                rst_pend <= 1'b0;
            if (reset_cond) begin
                swi_pend <= 1'b0;
                pre_swi  <= '0;
            end else if (swi_fetch) begin
                swi_pend <= 1'b1;
                pre_swi  <= hw_req & ~hw_taken;
            end else if (exc_ack && kind == EXC_SWI) begin
                swi_pend <= 1'b0;
                pre_swi  <= '0;
            end else begin
                pre_swi  <= pre_swi & ~hw_taken;
            end
        end
    end

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cond |-> (kind == EXC_RESET)); // R1
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        i_mask |-> (kind != EXC_IRQ && kind != EXC_PERIPH)); // R5
    AST_IMASK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> set_imask); // R2
    AST_IMASK_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> !set_imask); // R2
    AST_SWI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        swi_fetch |=> (kind != EXC_NONE)); // R3
endmodule

// File: rtl/exc_vector_arbiter.sv
// Module: top of the exception vector arbiter. Combines reset sources, the
// control byte, the pin detector and the selector, and forms vector addresses.
// Assumes all inputs are synchronous to clk.
module exc_vector_arbiter
    import exc_pkg::*;
#(
    parameter int                NPER     = 4,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0A,
    parameter logic [15:0]       VEC_BASE = 16'h3FF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_reset_n,
    input  logic              int_reset,
    input  logic              swi_fetch,
    input  logic              i_mask,
    input  logic              irq_pin,
    input  logic [NPER-1:0]   periph_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              exc_ack,
    output logic              exc_take,
    output logic [2:0]        exc_kind,
    output logic [15:0]       vec_hi_addr,
    output logic [15:0]       vec_lo_addr,
    output logic              set_imask
);
    logic      reset_cond;
    logic      irq_en;
    logic [1:0] irq_mode;
    logic      irq_active;
    logic      irq_ack;
    exc_kind_e kind;

    assign reset_cond = ~ext_reset_n | int_reset;

    exc_sysctl #(.ADDR_W(ADDR_W), .DATA_W(8), .CTL_ADDR(CTL_ADDR)) u_sysctl (
        .clk(clk), .rst_n(rst_n), .clr(reset_cond),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_en(irq_en), .irq_mode(irq_mode)
    );

    exc_irq_sense u_sense (
        .clk(clk), .rst_n(rst_n), .clr(reset_cond), .irq_pin(irq_pin),
        .irq_en(irq_en), .irq_mode(irq_mode), .irq_ack(irq_ack),
        .irq_active(irq_active)
    );

    exc_priority #(.NPER(NPER)) u_prio (
        .clk(clk), .rst_n(rst_n), .reset_cond(reset_cond), .i_mask(i_mask),
        .irq_active(irq_active), .periph_req(periph_req),
        .swi_fetch(swi_fetch), .exc_ack(exc_ack), .kind(kind),
        .irq_ack(irq_ack), .set_imask(set_imask)
    );

    // Purpose: form the vector byte addresses for the selected kind
    always_comb begin
        exc_kind = kind;
        exc_take = (kind != EXC_NONE);
        if (kind == EXC_NONE) begin
            vec_hi_addr = '0;
            vec_lo_addr = '0;
        end else begin
            vec_hi_addr = VEC_BASE + vec_offset(kind);
            vec_lo_addr = VEC_BASE + vec_offset(kind) + 16'd1;
        end
    end

    AST_TAKE_MATCHES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !exc_ack && !reset_cond && $stable(i_mask) && $stable(irq_pin)
         && $stable(periph_req) && !bus_we && kind == EXC_SWI) |=> exc_take); // R3
endmodule

// File: tb/exc_vector_arbiter_bench.sv
module exc_vector_arbiter_bench;
    localparam int NPER = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_reset_n = 1'b1;
    logic        int_reset = 1'b0;
    logic        swi_fetch = 1'b0;
    logic        i_mask = 1'b1;
    logic        irq_pin = 1'b1;
    logic [NPER-1:0] periph_req = '0;
    logic [7:0]  bus_addr = 8'h0A;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        exc_ack = 1'b0;
    logic        exc_take;
    logic [2:0]  exc_kind;
    logic [15:0] vec_hi_addr;
    logic [15:0] vec_lo_addr;
    logic        set_imask;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] kind;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    exc_vector_arbiter u_exc_vector_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_reset_n(ext_reset_n),
        .int_reset(int_reset), .swi_fetch(swi_fetch), .i_mask(i_mask),
        .irq_pin(irq_pin), .periph_req(periph_req), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .exc_ack(exc_ack), .exc_take(exc_take), .exc_kind(exc_kind),
        .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr),
        .set_imask(set_imask)
    );

    function automatic logic [15:0] exp_hi(logic [2:0] k);
        case (k)
            3'd1: return 16'h3FFE;
            3'd2: return 16'h3FFA;
            3'd3: return 16'h3FFC;
            3'd4: return 16'h3FF8;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_kind(logic [2:0] k, string tag);
        check(exc_kind == k, tag, exc_kind, k);
        check(exc_take == (k != 3'd0), {tag, " R11 take"}, exc_take, k != 3'd0);
    endtask

    // Monitor: pops expected items at each acknowledge and compares outputs
    always @(negedge clk) begin
        #2;
        if (exc_ack) begin
            if (expq.size() == 0) begin
                check(1'b0, "scoreboard empty", exc_kind, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(exc_kind == e.kind, {e.tag, " kind"}, exc_kind, e.kind);
                check(vec_hi_addr == exp_hi(e.kind), {e.tag, " R9 hi"},
                      vec_hi_addr, exp_hi(e.kind));
                check(vec_lo_addr == exp_hi(e.kind) + 16'd1, {e.tag, " R9 lo"},
                      vec_lo_addr, exp_hi(e.kind) + 16'd1);
            end
        end
    end

    // Driver: push expectation, acknowledge, then confirm the mask-set pulse
    task automatic take(logic [2:0] k, string tag);
        exp_t e;
        e.kind = k;
        e.tag  = tag;
        @(negedge clk);
        expq.push_back(e);
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
        #2;
        check(set_imask == 1'b1, "R2 set_imask after ack", set_imask, 1);
        @(negedge clk);
        #2;
        check(set_imask == 1'b0, "R2 set_imask one cycle", set_imask, 0);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        check_kind(3'd1, "R1 reset after block reset");
        check(bus_rdata == 8'h00, "R10 ctl reset value", bus_rdata, 0);
        take(3'd1, "R1");
        #1 check_kind(3'd0, "R1 idle after reset ack");

        // Falling edge while masked, then unmask
        wr(8'h01);
        @(negedge clk); irq_pin = 1'b0; periph_req = 4'b0100;
        cyc(2);
        check_kind(3'd0, "R5 masked");
        @(negedge clk); i_mask = 1'b0;
        #2 check_kind(3'd2, "R7 held edge, R9 irq first");
        take(3'd2, "R9 irq");
        check_kind(3'd4, "R7 edge cleared by ack");
        take(3'd4, "R9 periph");
        @(negedge clk); periph_req = '0;
        #2 check_kind(3'd0, "R8 no request");

        // Enable off
        wr(8'h02);
        @(negedge clk); irq_pin = 1'b1;
        cyc(2);
        check_kind(3'd0, "R6 enable off");
        // Rising mode
        wr(8'h03);
        @(negedge clk); irq_pin = 1'b0;
        cyc(2);
        check_kind(3'd0, "R7 fall ignored in rise mode");
        @(negedge clk); irq_pin = 1'b1;
        cyc(1);
        check_kind(3'd2, "R7 rising edge");
        take(3'd2, "R7 rise");
        // Both edges
        wr(8'h05);
        @(negedge clk); irq_pin = 1'b0;
        cyc(1);
        check_kind(3'd2, "R7 both fall");
        take(3'd2, "R7 both fall");
        @(negedge clk); irq_pin = 1'b1;
        cyc(1);
        check_kind(3'd2, "R7 both rise");
        take(3'd2, "R7 both rise");
        // Level
        wr(8'h07);
        check(bus_rdata == 8'h07, "R10 readback", bus_rdata, 7);
        @(negedge clk); irq_pin = 1'b0;
        #2 check_kind(3'd2, "R8 level low");
        @(negedge clk); irq_pin = 1'b1;
        #2 check_kind(3'd0, "R8 not latched");

        // SWI with mask set
        @(negedge clk); i_mask = 1'b1; swi_fetch = 1'b1;
        @(negedge clk); swi_fetch = 1'b0;
        #2 check_kind(3'd3, "R3 swi under mask");
        take(3'd3, "R3");

        // Earlier request ordered before SWI, later one after
        @(negedge clk); i_mask = 1'b0; irq_pin = 1'b0;
        @(negedge clk); swi_fetch = 1'b1;
        @(negedge clk); swi_fetch = 1'b0; periph_req = 4'b0001;
        #2 check_kind(3'd2, "R4 earlier irq first");
        take(3'd2, "R4 pre irq");
        take(3'd3, "R4 swi");
        @(negedge clk); irq_pin = 1'b1;
        take(3'd4, "R4 late periph");
        @(negedge clk); periph_req = '0;
        // SWI with nothing pending, peripheral arrives after
        @(negedge clk); swi_fetch = 1'b1;
        @(negedge clk); swi_fetch = 1'b0; periph_req = 4'b1000;
        #2 check_kind(3'd3, "R4 swi before late periph");
        take(3'd3, "R4 swi");
        take(3'd4, "R4 periph after");
        @(negedge clk); periph_req = '0;

        // Internal reset request clears the control byte
        @(negedge clk); int_reset = 1'b1; periph_req = 4'b0010;
        cyc(1);
        check_kind(3'd1, "R1 internal reset");
        check(bus_rdata == 8'h00, "R10 cleared by reset request", bus_rdata, 0);
        @(negedge clk); int_reset = 1'b0; periph_req = '0;
        #2 check_kind(3'd1, "R1 held until ack");
        take(3'd1, "R1 int");
        @(negedge clk); ext_reset_n = 1'b0;
        #2 check_kind(3'd1, "R1 reset pin");
        @(negedge clk); ext_reset_n = 1'b1;
        take(3'd1, "R1 pin");
        #1 check_kind(3'd0, "R1 idle after pin reset");

        cyc(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule